// File: doc/BRIEF.md
# Indirect interrupt redirection register window

This block is the register front end of an interrupt router. It holds a redirection table of 64-bit entries, one per interrupt pin, plus an identifier and a fixed version word. Software reaches all of them through two bus locations: a select byte that names an internal register, and a 32-bit data window that reads or writes the named register. Each table entry takes two window positions: the even one holds the low word and the odd one holds the high word. A third location accepts an explicit end-of-interrupt command, which the block passes on as a one-cycle vector pulse.

The complete table is driven out in parallel to a delivery engine. That engine owns two status bits in each entry. It sets and clears the remote-request bit through per-pin strobes, and it supplies the live delivery-busy flag. Software cannot change either bit. Every write to a table word sends a one-cycle service request to the engine, which then rescans the entries.

Top module: `irq_route_regs`

## Requirements
- R1: After reset the select byte and the identifier are zero, and every table entry reads 0x0000_0000_0001_0000, which is bit 16 (mask) set and all other bits clear.
- R2: Only address bits 7:0 are decoded. The select byte is at offset 0x00, the data window at 0x10 and the end-of-interrupt command at 0x40, whatever the value of the higher address bits.
- R3: A window access whose size is not 4 bytes has no effect. A window read of that kind returns zero. Read data appears in the cycle after the read strobe and is zero in every cycle that does not follow a read.
- R4: Select values from 0x10 upward address table entry (select − 0x10) >> 1. An even select reaches entry bits 31:0 and an odd select reaches entry bits 63:32. The last entry is at 0x3E/0x3F.
- R5: A window read with select 0x00 or 0x02 returns the identifier in bits 27:24. A window write with select 0x00 stores bits 27:24. Window writes with select 0x01 or 0x02 are discarded.
- R6: A window read with select 0x01 returns the version byte in bits 7:0 and (pin count − 1) in bits 23:16. This is 0x0017_0020 with the defaults.
- R7: Table writes leave the delivery-busy bit (bit 12) and the remote-request bit (bit 14) unchanged. Bit 12 always follows the engine's busy input for that pin.
- R8: After a table write, if the entry's trigger bit (bit 15) is 0, meaning edge, the entry's remote-request bit is cleared.
- R9: A 4-byte write to the end-of-interrupt offset produces a one-cycle pulse in the next cycle that carries bits 7:0 of the write data. This happens only when the version is 0x20. With version 0x11, or with any other write size, no pulse appears.
- R10: Each accepted table write raises the service request for exactly the next cycle. Writes to any other register do not raise it.
- R11: The engine's per-pin set strobe sets that entry's remote-request bit, and its clear strobe clears it. The change is visible on the table output in the next cycle.
- R12: Select values that name no register (0x03 to 0x0F, and 0x40 and above) read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after the read strobe |
| rirr_set | input | NPINS | Per-pin strobe that sets the remote-request bit |
| rirr_clr | input | NPINS | Per-pin strobe that clears the remote-request bit |
| dlv_busy | input | NPINS | Per-pin delivery-busy flag, mirrored into bit 12 |
| tbl_o | output | NPINS*64 | All table entries; entry i occupies bits i*64+63 to i*64 |
| svc_req | output | 1 | One-cycle rescan request after a table write |
| eoi_stb | output | 1 | One-cycle end-of-interrupt pulse |
| eoi_vec | output | 8 | Vector that accompanies eoi_stb |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that the set and clear strobes for one pin are never high together, and that every strobe is low during reset, because the per-entry properties look one cycle back to the previous strobe. The stimulus issues one access at a time through tasks that raise a strobe for exactly one cycle. The engine strobes are pulsed only between bus accesses, so the RTL's ordering of a strobe against a write in the same cycle is never exercised.

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int ADDR_W = 12,
  parameter int NPINS = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [2:0]            bus_size,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NPINS-1:0]      rirr_set,
  input  logic [NPINS-1:0]      rirr_clr,
  input  logic [NPINS-1:0]      dlv_busy,
  output logic [NPINS*64-1:0]   tbl_o,
  output logic                  svc_req,
  output logic                  eoi_stb,
  output logic [7:0]            eoi_vec
);
  localparam logic [7:0] SEL_OFF  = 8'h00;
  localparam logic [7:0] WIN_OFF  = 8'h10;
  localparam logic [7:0] EOI_OFF  = 8'h40;
  localparam logic [7:0] TBL_BASE = 8'h10;
  localparam int IDX_W = $clog2(NPINS);
  localparam logic [6:0] NP7 = 7'(NPINS);
  localparam logic [7:0] MAXENT = 8'(NPINS - 1);
  localparam int DLV = 12;
  localparam int RIRR = 14;
  localparam int TRIG = 15;
  localparam int MSK = 16;
  localparam logic [63:0] RO_MASK = (64'd1 << DLV) | (64'd1 << RIRR);
  localparam logic [63:0] RST_ENT = 64'd1 << MSK;
  localparam logic EOI_OK = (VERSION == 8'h20);

  logic [7:0]  sel;
  logic [3:0]  id;
  logic [63:0] ent_arr [NPINS];
  logic [31:0] rval;

  wire [7:0] off    = bus_addr[7:0];
  wire       win_ok = (off == WIN_OFF) && (bus_size == 3'd4);
  wire [7:0] rel    = sel - TBL_BASE;
  wire [6:0] idx    = rel[7:1];
  wire       in_tbl = (sel >= TBL_BASE) && (idx < NP7);
  wire       tbl_we = bus_wr && win_ok && in_tbl;

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_ent
    logic [63:0] ent, cur, nxt;
    wire hit = tbl_we && (idx == 7'(gi));

    always_comb begin
      cur = ent;
      cur[RIRR] = (cur[RIRR] | rirr_set[gi]) & ~rirr_clr[gi];
      cur[DLV] = dlv_busy[gi];
      nxt = cur;
      if (hit) begin
        if (sel[0]) nxt[63:32] = bus_wdata;
        else        nxt[31:0]  = bus_wdata;
        nxt = (nxt & ~RO_MASK) | (cur & RO_MASK);
        if (!nxt[TRIG]) nxt[RIRR] = 1'b0;
      end
    end

    always_ff @(posedge clk)
      if (!rst_n) ent <= RST_ENT;
      else        ent <= nxt;

    assign ent_arr[gi] = ent;
    assign tbl_o[gi*64 +: 64] = ent;

    assert_edge_rirr_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hit) && !ent[TRIG]) |-> !ent[RIRR]);

    assert_ro_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hit) && !$past(rirr_set[gi]) && !$past(rirr_clr[gi]))
        |-> (ent[DLV] == $past(dlv_busy[gi])) &&
            (ent[RIRR] == ($past(ent[RIRR]) && ent[TRIG])));

    assert_rirr_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rirr_set[gi]) && !$past(rirr_clr[gi]) && ent[TRIG]) |-> ent[RIRR]);
  end

  always_comb begin
    rval = '0;
    if (off == SEL_OFF) rval = {24'b0, sel};
    else if (win_ok) begin
      case (sel)
        8'h00, 8'h02: rval = {4'b0, id, 24'b0};
        8'h01:        rval = {8'b0, MAXENT, 8'b0, VERSION};
        default:
          if (in_tbl) rval = sel[0] ? ent_arr[idx[IDX_W-1:0]][63:32]
                                    : ent_arr[idx[IDX_W-1:0]][31:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= '0;
      id <= '0;
      bus_rdata <= '0;
      svc_req <= 1'b0;
      eoi_stb <= 1'b0;
      eoi_vec <= '0;
    end else begin
      if (bus_wr && off == SEL_OFF) sel <= bus_wdata[7:0];
      if (bus_wr && win_ok && sel == 8'h00) id <= bus_wdata[27:24];
      bus_rdata <= bus_rd ? rval : '0;
      svc_req <= tbl_we;
      eoi_stb <= bus_wr && off == EOI_OFF && bus_size == 3'd4 && EOI_OK;
      if (bus_wr && off == EOI_OFF) eoi_vec <= bus_wdata[7:0];
    end
  end

  assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> bus_rdata == 32'd0);

  assert_svc_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(bus_wr) && $past(bus_addr[7:0]) == WIN_OFF && $past(bus_size) == 3'd4);

  assert_eoi_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_stb |-> $past(bus_wr) && $past(bus_size) == 3'd4 && eoi_vec == $past(bus_wdata[7:0]));

  assert_eoi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_stb |=> !eoi_stb || $past(bus_wr));
endmodule

// File: tb/irq_route_regs_test.sv
module irq_route_regs_test;
  logic clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_size = 3'd4;
  logic [31:0] bus_wdata = '0;
  logic [23:0] rirr_set = '0, rirr_clr = '0, dlv_busy = '0;
  logic [31:0] bus_rdata, rdata_b;
  logic [24*64-1:0] tbl_o, tbl_b;
  logic svc_req, eoi_stb, svc_b, eoi_b;
  logic [7:0] eoi_vec, vec_b;
  int checks = 0, errors = 0;
  bit done = 0;
  logic svc_seen, eoi_seen, eoi_b_seen;
  logic [7:0] vec_seen;
  logic [31:0] v;

  always #4 clk = ~clk;

  irq_route_regs uut (.clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_size, .bus_wdata,
    .bus_rdata, .rirr_set, .rirr_clr, .dlv_busy, .tbl_o, .svc_req, .eoi_stb, .eoi_vec);

  irq_route_regs #(.VERSION(8'h11)) uut_b (.clk, .rst_n, .bus_addr, .bus_wr, .bus_rd,
    .bus_size, .bus_wdata, .bus_rdata(rdata_b), .rirr_set, .rirr_clr, .dlv_busy,
    .tbl_o(tbl_b), .svc_req(svc_b), .eoi_stb(eoi_b), .eoi_vec(vec_b));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    svc_seen = svc_req; eoi_seen = eoi_stb; vec_seen = eoi_vec; eoi_b_seen = eoi_b;
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  function automatic logic [63:0] ent(input int i);
    return tbl_o[i*64 +: 64];
  endfunction

  task automatic t_reset;
    rd(12'h000, 3'd4, v);   check("R1 select", v, 0);
    check("R1 entry0", ent(0), 64'h10000);
    check("R1 entry23", ent(23), 64'h10000);
    check("R3 idle rdata", bus_rdata, 0);
    rd(12'h010, 3'd4, v);   check("R1 id", v, 0);
  endtask

  task automatic t_id_ver;
    wr(12'h000, 3'd4, 32'h1);
    rd(12'h010, 3'd4, v);   check("R6 version", v, 32'h0017_0020);
    check("R6 version b", rdata_b, 32'h0017_0011);
    wr(12'h010, 3'd4, 32'hFFFF_FFFF);
    rd(12'h010, 3'd4, v);   check("R5 version write dropped", v, 32'h0017_0020);
    wr(12'h000, 3'd4, 32'h0);
    wr(12'h010, 3'd4, 32'h5A00_0000);
    check("R10 no svc on id write", svc_seen, 0);
    rd(12'h010, 3'd4, v);   check("R5 id read", v, 32'h0A00_0000);
    wr(12'h000, 3'd4, 32'h2);
    rd(12'h010, 3'd4, v);   check("R5 arb read", v, 32'h0A00_0000);
    wr(12'h010, 3'd4, 32'h0);
    wr(12'h000, 3'd4, 32'h0);
    rd(12'h010, 3'd4, v);   check("R5 arb write dropped", v, 32'h0A00_0000);
  endtask

  task automatic t_table;
    wr(12'h000, 3'd4, 32'h16);
    wr(12'h010, 3'd4, 32'h0001_8031);
    check("R10 svc lower", svc_seen, 1);
    wr(12'h000, 3'd4, 32'h17);
    wr(12'h010, 3'd4, 32'hAB00_0000);
    check("R10 svc upper", svc_seen, 1);
    check("R4 entry3", ent(3), 64'hAB00_0000_0001_8031);
    rd(12'h010, 3'd4, v);   check("R4 upper read", v, 32'hAB00_0000);
    wr(12'h000, 3'd4, 32'h3E);
    wr(12'h010, 3'd4, 32'h0000_00F0);
    wr(12'h000, 3'd4, 32'h3F);
    wr(12'h010, 3'd4, 32'h0F00_0000);
    check("R4 last entry", ent(23), 64'h0F00_0000_0000_00F0);
    check("R4 neighbour untouched", ent(22), 64'h10000);
  endtask

  task automatic t_ro_bits;
    @(negedge clk); dlv_busy[3] = 1;
    @(negedge clk); rirr_set[3] = 1;
    @(negedge clk); rirr_set[3] = 0;
    check("R11 set strobe", ent(3), 64'hAB00_0000_0001_D031);
    wr(12'h000, 3'd4, 32'h16);
    wr(12'h010, 3'd4, 32'h0000_8042);
    check("R7 ro kept level", ent(3), 64'hAB00_0000_0000_D042);
    wr(12'h010, 3'd4, 32'h0000_0042);
    check("R8 edge clears rirr", ent(3), 64'hAB00_0000_0000_1042);
    @(negedge clk); dlv_busy[3] = 0;
    wr(12'h010, 3'd4, 32'h0000_D000);
    check("R7 ro not writable", ent(3), 64'hAB00_0000_0000_8000);
    @(negedge clk); rirr_set[3] = 1;
    @(negedge clk); rirr_set[3] = 0;
    check("R11 set again", ent(3), 64'hAB00_0000_0000_C000);
    @(negedge clk); rirr_clr[3] = 1;
    @(negedge clk); rirr_clr[3] = 0;
    check("R11 clear strobe", ent(3), 64'hAB00_0000_0000_8000);
  endtask

  task automatic t_size_addr;
    wr(12'h000, 3'd4, 32'h16);
    wr(12'h010, 3'd2, 32'h0000_0077);
    check("R3 short write no svc", svc_seen, 0);
    check("R3 short write ignored", ent(3), 64'hAB00_0000_0000_8000);
    rd(12'h010, 3'd2, v);   check("R3 short read zero", v, 0);
    wr(12'hF00, 3'd4, 32'h17);
    rd(12'h510, 3'd4, v);   check("R2 aliased window", v, 32'hAB00_0000);
    wr(12'hA10, 3'd4, 32'hCD00_0000);
    check("R2 aliased write", ent(3), 64'hCD00_0000_0000_8000);
  endtask

  task automatic t_unmapped;
    wr(12'h000, 3'd4, 32'h40);
    wr(12'h010, 3'd4, 32'hFFFF_FFFF);
    check("R12 no svc past table", svc_seen, 0);
    rd(12'h010, 3'd4, v);   check("R12 past table reads zero", v, 0);
    wr(12'h000, 3'd4, 32'h05);
    wr(12'h010, 3'd4, 32'hFFFF_FFFF);
    check("R12 hole no svc", svc_seen, 0);
    rd(12'h010, 3'd4, v);   check("R12 hole reads zero", v, 0);
    check("R12 entry0 kept", ent(0), 64'h10000);
  endtask

  task automatic t_eoi;
    wr(12'h040, 3'd4, 32'h1234_567E);
    check("R9 eoi pulse", eoi_seen, 1);
    check("R9 eoi vector", vec_seen, 8'h7E);
    check("R9 no eoi on v11", eoi_b_seen, 0);
    check("R10 no svc on eoi", svc_seen, 0);
    @(negedge clk);
    check("R9 pulse one cycle", eoi_stb, 0);
    wr(12'h440, 3'd1, 32'h0000_0033);
    check("R9 short eoi ignored", eoi_seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_id_ver;
    t_table;
    t_ro_bits;
    t_size_addr;
    t_unmapped;
    t_eoi;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule